// File: doc/BRIEF.md
# Multi-Format Stereo Audio Receiver

This block deserialises serial audio for a six-channel converter that arrives on three data lines. All three lines share one bit clock and one word clock, and the block deserialises them in parallel. Each line carries a time-multiplexed stereo pair. The word clock tells left apart from right. It also marks where each word starts or ends, depending on the framing format.

The framing format and the word length are chosen at run time through two select inputs. Settings that are not supported raise an error flag and produce no samples. The block runs entirely on the rising edge of the bit clock. When a complete left/right pair is available, it presents the left and right samples of every line at once and asserts a one-cycle valid strobe. Word-clock phases that are too short to hold a word set a sticky framing-error flag.

Top module: `stereo_rx`

## Requirements
- R1: Every data line is shifted most-significant bit first. Each sample is presented right-aligned and zero-extended in its DW-bit slot. Line i occupies bits [i*DW +: DW] of `left_pcm` and `right_pcm`, and all lines are captured on the same edges.
- R2: With `fmt_sel` = 0 (left-aligned), the MSB is the bit sampled on the first rising edge at which `word_clk` differs from its value at the previous edge.
- R3: With `fmt_sel` = 2 (one-bit-delayed), the MSB is the bit sampled on the second rising edge after a `word_clk` change.
- R4: With `fmt_sel` = 1 (right-aligned), the LSB is the bit sampled on the last rising edge before the next `word_clk` change. The word is the last N bits received before that change.
- R5: `wlen_sel` picks the word length N: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32 bits.
- R6: A high `word_clk` carries the left word and a low one carries the right word. `pcm_valid` is high for exactly one cycle, the cycle after the edge that completes a right word that follows a captured left word. Both outputs update only at that moment and hold otherwise.
- R7: Bits beyond the N word bits in a phase are ignored, and any duty cycle is accepted when each phase lasts at least N bit clocks.
- R8: `fmt_sel` = 1 with `wlen_sel` = 3, or `fmt_sel` = 3, is illegal. `cfg_err` goes high from the next cycle and no `pcm_valid` is produced while the setting stays illegal.
- R9: A `word_clk` phase shorter than N bit clocks, measured from the first change after reset, sets `frame_err`. The flag stays set until `rst_n` is asserted, and the pair holding the short phase is not output.
- R10: While `rst_n` is low, and after it is released until the first output, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all logic samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the framing error |
| fmt_sel | input | 2 | Framing format: 0 left-aligned, 1 right-aligned, 2 one-bit-delayed, 3 reserved |
| wlen_sel | input | 2 | Word length: 0/1/2/3 for 16/20/24/32 bits |
| word_clk | input | 1 | Left/right word clock, high for left |
| sdin | input | NLINES | Serial data, one bit per line |
| left_pcm | output | NLINES*DW | Left samples, line i at bits [i*DW +: DW] |
| right_pcm | output | NLINES*DW | Right samples, same layout |
| pcm_valid | output | 1 | One-cycle strobe when a new pair is presented |
| cfg_err | output | 1 | Illegal format/length combination selected |
| frame_err | output | 1 | Sticky: a word-clock phase was shorter than the word length |

## Verification
The assertions assume that `fmt_sel` and `wlen_sel` change only while reset is held. Under that assumption the registered configuration error lines up with the suppression of the strobe. They also rely on each word-clock phase being at least 16 bit clocks long, so that two valid strobes can never fall on adjacent cycles. The bench reprograms the format only inside reset, and it keeps every phase above the word length except in the single case that deliberately provokes the framing error.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;

  localparam int unsigned CNT_W = 6;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_RJ  = 2'd1,
    FMT_I2S = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  // Word length in bits for the length select code.
  function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      2'd0:    n = CNT_W'(16);
      2'd1:    n = CNT_W'(20);
      2'd2:    n = CNT_W'(24);
      default: n = CNT_W'(32);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/stereo_rx_ctrl.sv
module stereo_rx_ctrl
  import stereo_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fmt_sel,
  input  logic [1:0] wlen_sel,
  input  logic       word_clk,
  output logic       ld_first,
  output logic       shift_en,
  output logic       cap_incl,
  output logic       hold_left,
  output logic       publish,
  output logic       pcm_valid,
  output logic       cfg_err,
  output logic       frame_err
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  fmt_e             fmt;
  logic [CNT_W-1:0] nbits;
  logic             illegal, tr, start, filling, word_done, rj_done, cap_side;

  // registered state
  logic             wclk_q, primed_q, synced_q, tr_q, side_q, left_ok_q;
  logic             ferr_q, cfg_err_q, valid_q;
  logic [CNT_W-1:0] cnt_q, plen_q;

  // next state
  logic             wclk_d, primed_d, synced_d, tr_d, side_d, left_ok_d;
  logic             ferr_d, cfg_err_d, valid_d;
  logic [CNT_W-1:0] cnt_d, plen_d;

  assign fmt = fmt_e'(fmt_sel);

  always_comb begin
    nbits     = wlen_bits(wlen_sel);
    illegal   = (fmt == FMT_RSV) || ((fmt == FMT_RJ) && (wlen_sel == 2'd3));
    tr        = primed_q && (word_clk != wclk_q);
    // new word begins at the change (left-aligned) or one edge later (delayed)
    start     = !illegal && (((fmt == FMT_LJ) && tr) || ((fmt == FMT_I2S) && tr_q));
    filling   = (fmt != FMT_RJ) && !start && (cnt_q < nbits);
    word_done = !illegal && filling && (cnt_q == nbits - CNT_W'(1));
    rj_done   = !illegal && (fmt == FMT_RJ) && tr && synced_q && (plen_q >= nbits);
    cap_side  = word_done ? side_q : wclk_q;
    hold_left = (word_done || rj_done) && cap_side;
    publish   = (word_done || rj_done) && !cap_side && left_ok_q;
    ld_first  = start;
    shift_en  = (fmt == FMT_RJ) || filling;
    cap_incl  = word_done;

    wclk_d    = word_clk;
    primed_d  = 1'b1;
    synced_d  = synced_q || tr;
    tr_d      = tr;
    side_d    = side_q;
    cnt_d     = cnt_q;
    if (start) begin
      side_d = word_clk;
      cnt_d  = CNT_W'(1);
    end else if (filling) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
    if (tr)                 plen_d = CNT_W'(1);
    else if (plen_q == SAT) plen_d = plen_q;
    else                    plen_d = plen_q + CNT_W'(1);
    ferr_d    = ferr_q || (tr && synced_q && (plen_q < nbits));
    left_ok_d = left_ok_q;
    if (hold_left)    left_ok_d = 1'b1;
    else if (publish) left_ok_d = 1'b0;
    valid_d   = publish;
    cfg_err_d = illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q    <= 1'b0;
      primed_q  <= 1'b0;
      synced_q  <= 1'b0;
      tr_q      <= 1'b0;
      side_q    <= 1'b0;
      left_ok_q <= 1'b0;
      ferr_q    <= 1'b0;
      cfg_err_q <= 1'b0;
      valid_q   <= 1'b0;
      cnt_q     <= SAT;
      plen_q    <= '0;
    end else begin
      wclk_q    <= wclk_d;
      primed_q  <= primed_d;
      synced_q  <= synced_d;
      tr_q      <= tr_d;
      side_q    <= side_d;
      left_ok_q <= left_ok_d;
      ferr_q    <= ferr_d;
      cfg_err_q <= cfg_err_d;
      valid_q   <= valid_d;
      cnt_q     <= cnt_d;
      plen_q    <= plen_d;
    end
  end

  assign pcm_valid = valid_q;
  assign cfg_err   = cfg_err_q;
  assign frame_err = ferr_q;

endmodule

// File: rtl/stereo_rx_lane.sv
module stereo_rx_lane
  import stereo_rx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdin,
  input  logic [1:0]    wlen_sel,
  input  logic          ld_first,
  input  logic          shift_en,
  input  logic          cap_incl,
  input  logic          hold_left,
  input  logic          publish,
  output logic [DW-1:0] left_pcm,
  output logic [DW-1:0] right_pcm
);

  logic [DW-1:0]    sh_q, sh_d, lhold_q, lout_q, rout_q, word, mask;
  logic [CNT_W-1:0] nbits;

  always_comb begin
    nbits = wlen_bits(wlen_sel);
    mask  = DW'((64'd1 << nbits) - 64'd1);
    word  = (cap_incl ? {sh_q[DW-2:0], sdin} : sh_q) & mask;
    if (ld_first)      sh_d = {{(DW-1){1'b0}}, sdin};
    else if (shift_en) sh_d = {sh_q[DW-2:0], sdin};
    else               sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      lhold_q <= '0;
      lout_q  <= '0;
      rout_q  <= '0;
    end else begin
      sh_q <= sh_d;
      if (hold_left) lhold_q <= word;
      if (publish) begin
        lout_q <= lhold_q;
        rout_q <= word;
      end
    end
  end

  assign left_pcm  = lout_q;
  assign right_pcm = rout_q;

endmodule

// File: rtl/stereo_rx.sv
module stereo_rx
  import stereo_rx_pkg::*;
#(
  parameter int unsigned NLINES = 3,
  parameter int unsigned DW     = 32
) (
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic [1:0]           fmt_sel,
  input  logic [1:0]           wlen_sel,
  input  logic                 word_clk,
  input  logic [NLINES-1:0]    sdin,
  output logic [NLINES*DW-1:0] left_pcm,
  output logic [NLINES*DW-1:0] right_pcm,
  output logic                 pcm_valid,
  output logic                 cfg_err,
  output logic                 frame_err
);

  logic ld_first, shift_en, cap_incl, hold_left, publish;

  stereo_rx_ctrl u_ctrl (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .wlen_sel  (wlen_sel),
    .word_clk  (word_clk),
    .ld_first  (ld_first),
    .shift_en  (shift_en),
    .cap_incl  (cap_incl),
    .hold_left (hold_left),
    .publish   (publish),
    .pcm_valid (pcm_valid),
    .cfg_err   (cfg_err),
    .frame_err (frame_err)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_lane
    stereo_rx_lane #(.DW(DW)) u_lane (
      .clk       (bit_clk),
      .rst_n     (rst_n),
      .sdin      (sdin[i]),
      .wlen_sel  (wlen_sel),
      .ld_first  (ld_first),
      .shift_en  (shift_en),
      .cap_incl  (cap_incl),
      .hold_left (hold_left),
      .publish   (publish),
      .left_pcm  (left_pcm[i*DW +: DW]),
      .right_pcm (right_pcm[i*DW +: DW])
    );
  end

endmodule

// File: rtl/stereo_rx_chk.sv
module stereo_rx_chk #(
  parameter int unsigned NLINES = 3,
  parameter int unsigned DW     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           fmt_sel,
  input logic [1:0]           wlen_sel,
  input logic [NLINES*DW-1:0] left_pcm,
  input logic [NLINES*DW-1:0] right_pcm,
  input logic                 pcm_valid,
  input logic                 cfg_err,
  input logic                 frame_err
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);                                          // R6
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> ($stable(left_pcm) && $stable(right_pcm)));         // R6
  AST_CFG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel == 2'd3 || (fmt_sel == 2'd1 && wlen_sel == 2'd3)) |=> cfg_err); // R8
  AST_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !pcm_valid);                                            // R8
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);                                           // R9

endmodule

bind stereo_rx stereo_rx_chk #(.NLINES(NLINES), .DW(DW)) u_chk (
  .clk       (bit_clk),
  .rst_n     (rst_n),
  .fmt_sel   (fmt_sel),
  .wlen_sel  (wlen_sel),
  .left_pcm  (left_pcm),
  .right_pcm (right_pcm),
  .pcm_valid (pcm_valid),
  .cfg_err   (cfg_err),
  .frame_err (frame_err)
);

// File: tb/stereo_rx_bench.sv
`timescale 1ns/1ps
module stereo_rx_bench;

  localparam int NL = 3;
  localparam int DW = 32;

  logic             bit_clk = 1'b0;
  logic             rst_n;
  logic [1:0]       fmt_sel, wlen_sel;
  logic             word_clk;
  logic [NL-1:0]    sdin;
  logic [NL*DW-1:0] left_pcm, right_pcm;
  logic             pcm_valid, cfg_err, frame_err;

  stereo_rx #(.NLINES(NL), .DW(DW)) u_stereo_rx (
    .bit_clk, .rst_n, .fmt_sel, .wlen_sel, .word_clk, .sdin,
    .left_pcm, .right_pcm, .pcm_valid, .cfg_err, .frame_err
  );

  always #10 bit_clk = ~bit_clk;   // 50 MHz

  int checks = 0;
  int fails  = 0;
  logic [NL*DW-1:0] exp_l[$];
  logic [NL*DW-1:0] exp_r[$];
  string            exp_tag[$];
  logic [NL-1:0]    prev_bits;
  int               cur_fmt, cur_n;
  logic             done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [NL*DW-1:0] act,
                       input logic [NL*DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic bit_at(input int fmtv, input int len, input int n,
                                  input int p, input logic [31:0] w);
    if (fmtv == 1) return (p >= len - n) ? w[len-1-p] : 1'b1;
    return (p < n) ? w[n-1-p] : 1'b1;
  endfunction

  // One bit-clock slot; the delayed format sees the stream one slot late.
  task automatic drive_slot(input logic wc, input logic [NL-1:0] bits);
    @(negedge bit_clk);
    word_clk = wc;
    if (cur_fmt == 2) sdin = prev_bits;
    else              sdin = bits;
    prev_bits = bits;
  endtask

  task automatic send_phase(input logic wc, input int len, input logic [NL*DW-1:0] words);
    for (int p = 0; p < len; p++) begin
      logic [NL-1:0] b;
      for (int i = 0; i < NL; i++) b[i] = bit_at(cur_fmt, len, cur_n, p, words[i*DW +: 32]);
      drive_slot(wc, b);
    end
  endtask

  task automatic send_frame(input int ll, input int lr, input bit push, input string tag);
    logic [NL*DW-1:0] l, r;
    logic [31:0] m;
    m = (cur_n == 32) ? 32'hFFFF_FFFF : ((32'd1 << cur_n) - 32'd1);
    for (int i = 0; i < NL; i++) begin
      l[i*DW +: DW] = DW'($urandom & m);
      r[i*DW +: DW] = DW'($urandom & m);
    end
    if (push) begin
      exp_l.push_back(l);
      exp_r.push_back(r);
      exp_tag.push_back(tag);
    end
    send_phase(1'b1, ll, l);
    send_phase(1'b0, lr, r);
  endtask

  task automatic begin_burst(input int f, input int w);
    @(negedge bit_clk);
    rst_n = 1'b0; fmt_sel = 2'(f); wlen_sel = 2'(w);
    word_clk = 1'b0; sdin = '0; prev_bits = '0;
    cur_fmt = f;
    cur_n = (w == 0) ? 16 : (w == 1) ? 20 : (w == 2) ? 24 : 32;
    repeat (3) @(negedge bit_clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) drive_slot(1'b0, '0);
  endtask

  task automatic end_burst();
    send_phase(1'b1, cur_n + 2, '0);
    for (int k = 0; k < 4; k++) drive_slot(1'b1, '0);
  endtask

  // Monitor: pop one expected pair per strobe.
  logic prev_valid = 1'b0;
  always @(negedge bit_clk) begin
    if (rst_n === 1'b1 && pcm_valid === 1'b1) begin
      check(prev_valid == 1'b0, "R6 strobe width", {95'd0, prev_valid}, '0);
      if (exp_l.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", left_pcm, '0);
      end else begin
        logic [NL*DW-1:0] el, er;
        string t;
        el = exp_l.pop_front(); er = exp_r.pop_front(); t = exp_tag.pop_front();
        check(left_pcm == el,  {t, " R1 left"},  left_pcm,  el);
        check(right_pcm == er, {t, " R1 right"}, right_pcm, er);
      end
    end
    prev_valid = (rst_n === 1'b1) && (pcm_valid === 1'b1);
  end

  initial begin
    repeat (150000) @(posedge bit_clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fmt_sel = 2'd0; wlen_sel = 2'd0; word_clk = 1'b0; sdin = '0;
    prev_bits = '0; cur_fmt = 0; cur_n = 16;
    repeat (3) @(negedge bit_clk);
    check(left_pcm == '0 && right_pcm == '0, "R10 reset data", left_pcm | right_pcm, '0);
    check({pcm_valid, cfg_err, frame_err} == 3'b000, "R10 reset flags",
          {93'd0, pcm_valid, cfg_err, frame_err}, '0);

    // R2 left-aligned, 16 bits, uneven duty and padded phases
    begin_burst(0, 0);
    send_frame(16, 16, 1, "R2");
    send_frame(20, 17, 1, "R2 R7");
    send_frame(40, 16, 1, "R2 R7");
    end_burst();
    check(frame_err == 1'b0 && cfg_err == 1'b0, "R7 no error on legal stream",
          {94'd0, cfg_err, frame_err}, '0);

    // R5 left-aligned, 32 bits
    begin_burst(0, 3);
    send_frame(32, 32, 1, "R5");
    send_frame(35, 40, 1, "R5 R7");
    end_burst();

    // R3 delayed format, 24 bits, phases exactly N included
    begin_burst(2, 2);
    send_frame(24, 24, 1, "R3");
    send_frame(30, 26, 1, "R3");
    send_frame(24, 31, 1, "R3");
    end_burst();

    // R4 right-aligned, 20 bits
    begin_burst(1, 1);
    send_frame(20, 20, 1, "R4");
    send_frame(28, 22, 1, "R4 R7");
    send_frame(20, 33, 1, "R4");
    end_burst();

    // R5 right-aligned 24 bits
    begin_burst(1, 2);
    send_frame(32, 32, 1, "R4 R5");
    end_burst();

    // R8 right-aligned with 32 bits is illegal
    begin_burst(1, 3);
    check(cfg_err == 1'b1, "R8 cfg_err rj32", {95'd0, cfg_err}, 1);
    send_frame(32, 32, 0, "R8");
    send_frame(40, 36, 0, "R8");
    end_burst();
    check(cfg_err == 1'b1, "R8 cfg_err held", {95'd0, cfg_err}, 1);

    // R8 reserved format code
    begin_burst(3, 0);
    check(cfg_err == 1'b1, "R8 cfg_err reserved", {95'd0, cfg_err}, 1);
    send_frame(16, 16, 0, "R8");
    end_burst();

    // R9 short left phase
    begin_burst(0, 0);
    check(frame_err == 1'b0, "R9 clear before", {95'd0, frame_err}, 0);
    send_frame(10, 16, 0, "R9");
    repeat (2) @(negedge bit_clk);
    check(frame_err == 1'b1, "R9 frame_err set", {95'd0, frame_err}, 1);
    send_frame(16, 16, 1, "R9 recover");
    end_burst();
    check(frame_err == 1'b1, "R9 frame_err sticky", {95'd0, frame_err}, 1);
    @(negedge bit_clk); rst_n = 1'b0;
    @(negedge bit_clk);
    check(frame_err == 1'b0, "R9 cleared by reset", {95'd0, frame_err}, 0);

    repeat (4) @(negedge bit_clk);
    check(exp_l.size() == 0, "R6 all pairs delivered", 96'(exp_l.size()), '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule